// File: doc/BRIEF.md
# Receive Character Queue with Prioritized Interrupt Identification

This block sits between the receive deserializer of an asynchronous serial channel and the byte-wide register interface that a host reads. It holds up to sixteen received characters. Each character keeps its own parity, framing and break marks. The oldest character and its marks are presented at the head of the queue, and the host removes it with a read strobe.

The block raises a receive interrupt in two cases. The first is when the queue fill reaches a programmable threshold. The second is when characters sit unread and no serial or host activity occurs for four character times. Four interrupt sources are ranked, and the block reports the highest-ranked pending one through an 8-bit identification byte.

A legacy single-character mode disables queueing. In that mode the block behaves like a one-byte holding register and has no timeout. The transmit-empty and modem-change sources arrive as plain levels from neighbouring logic.

Top module: `rxq_irq_top`

## Requirements
- R1: In queue mode (`fifo_mode`=1) the receive-data source is pending when the fill is at or above the threshold that `trig_sel` selects: 00→1, 01→4, 10→8, 11→14 characters. In single mode the threshold is 1.
- R2: The receive-data source clears by itself on the cycle after a read brings the fill below the threshold.
- R3: Characters leave in arrival order. `head_byte` and `head_pe`/`head_fe`/`head_bi` show the oldest stored character, `rd_pop` removes it, and `fill_level` counts the stored characters.
- R4: A character that arrives while the queue is full, with no read in the same cycle, is dropped. It sets the overrun flag `line_flags[0]` and leaves the stored contents unchanged.
- R5: In queue mode with at least one character stored, the timeout becomes pending after 4×(7 + `word_len` + `two_stop`) consecutive cycles in which `baud_tick` is high and there is no arrival, read or flush. Any arrival or read clears it.
- R6: In single mode the capacity is one character and the timeout never becomes pending.
- R7: `iir[3:0]` gives the highest-ranked pending source: line status 0110, receive data 0100, timeout 1100, transmit empty 0010, modem 0000. It reads 0001 when nothing is pending.
- R8: `iir[7:6]` reads 11 in queue mode and 00 in single mode. `iir[5:4]` is 00. `iir[3]` is always 0 in single mode.
- R9: `fifo_err` sets when a stored character carries a parity, framing or break mark in queue mode. A `rd_lsr` pulse clears it, except that a new error arriving in the same cycle wins.
- R10: `line_flags` = {break, framing, parity, overrun} are sticky and cleared by `rd_lsr`. `ien_line` gates the line-status source, `ien_modem` gates the modem source, `ien_thre` gates transmit empty, and `ien_rx` gates both receive sources.
- R11: A `fifo_flush` pulse, or any change of `fifo_mode`, empties the queue, drops an arrival in that same cycle, and clears `fifo_err` and the timeout.
- R12: `irq` is high exactly when some enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = sixteen-entry queue mode, 0 = single-character mode |
| trig_sel | input | 2 | Receive threshold select |
| fifo_flush | input | 1 | Pulse: empty the queue |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | 1 = two stop bits |
| baud_tick | input | 1 | One pulse per serial bit time |
| rx_valid | input | 1 | Deserializer delivers a character |
| rx_byte | input | 8 | Received character |
| rx_pe | input | 1 | Parity error mark of the character |
| rx_fe | input | 1 | Framing error mark of the character |
| rx_bi | input | 1 | Break mark of the character |
| rd_pop | input | 1 | Host reads the receive data register |
| rd_lsr | input | 1 | Host reads the line status register |
| ien_rx | input | 1 | Enable for receive data and timeout |
| ien_thre | input | 1 | Enable for transmit empty |
| ien_line | input | 1 | Enable for line status |
| ien_modem | input | 1 | Enable for modem status |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_event | input | 1 | Modem status change pending level |
| head_byte | output | 8 | Oldest stored character |
| head_pe | output | 1 | Parity mark of the oldest character |
| head_fe | output | 1 | Framing mark of the oldest character |
| head_bi | output | 1 | Break mark of the oldest character |
| fill_level | output | 5 | Number of stored characters |
| line_flags | output | 4 | Sticky {break, framing, parity, overrun} |
| fifo_err | output | 1 | An errored character has entered the queue |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle: the fill bound, the contents freezing across an overrun, the timeout never standing without stored data or outside queue mode, the line-status source taking precedence, the legacy identification bits, the threshold code, and the `fifo_err` clear. Some behaviours only the bench scenarios can show. These are arrival order through a full wrap, the exact tick count at which the timeout fires for different character formats, the self-clearing of the threshold source after reads, the set-over-clear race on `fifo_err`, and the drop of the queue on a mode change. The bench's reference model tracks all outputs on every clock while these scenarios run.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              pe;
        logic              fe;
        logic              bi;
    } rx_entry_t;

    typedef struct packed {
        logic line;
        logic rda;
        logic cto;
        logic thre;
        logic modem;
    } irq_src_t;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_THRE  = 3'b001,
        ID_RDA   = 3'b010,
        ID_LINE  = 3'b011,
        ID_CTO   = 3'b110
    } irq_id_e;

    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    // start bit + data bits + stop bits
    function automatic int char_bits(input logic [1:0] wl, input logic two);
        return 7 + int'(wl) + int'(two);
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [$clog2(DEPTH+1)-1:0]   cap,
    input  rx_entry_t                    din,
    output rx_entry_t                    head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         accepted,
    output logic                         ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic            full, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = count >= cap;
    assign do_pop   = !flush && pop && (count != '0);
    assign accepted = !flush && push && (!full || do_pop);
    assign ovf      = !flush && push && full && !do_pop;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) wr_ptr <= bump(wr_ptr);
            if (do_pop)   rd_ptr <= bump(rd_ptr);
            case ({accepted, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    assert_overrun_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> count == $past(count));

endmodule

// File: rtl/rxq_timeout.sv
`timescale 1ns/1ps
module rxq_timeout
    import rxq_pkg::*;
#(
    parameter int TO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       has_data,
    input  logic       activity,
    input  logic       baud_tick,
    input  logic [1:0] word_len,
    input  logic       two_stop,
    output logic       timed_out
);
    localparam int MAX_LIM = TO_CHARS * 12;
    localparam int TW      = $clog2(MAX_LIM + 1);

    logic [TW-1:0] ticks;
    int            limit;

    always_comb limit = TO_CHARS * char_bits(word_len, two_stop);

    always_ff @(posedge clk) begin
        if (rst || !enable || activity || !has_data) begin
            ticks     <= '0;
            timed_out <= 1'b0;
        end else if (baud_tick && !timed_out) begin
            if (int'(ticks) + 1 >= limit) timed_out <= 1'b1;
            else                          ticks     <= ticks + 1'b1;
        end
    end

    assert_cto_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        timed_out |-> has_data);

    assert_cto_queue_only_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !timed_out);

endmodule

// File: rtl/rxq_prio.sv
`timescale 1ns/1ps
module rxq_prio
    import rxq_pkg::*;
(
    input  logic     fifo_mode,
    input  irq_src_t src,
    output logic [7:0] iir
);
    irq_id_e id;
    logic    none;

    always_comb begin
        none = 1'b0;
        id   = ID_MODEM;
        if      (src.line)  id = ID_LINE;
        else if (src.rda)   id = ID_RDA;
        else if (src.cto)   id = ID_CTO;
        else if (src.thre)  id = ID_THRE;
        else if (src.modem) id = ID_MODEM;
        else                none = 1'b1;
        iir = {fifo_mode, fifo_mode, 2'b00, fifo_mode & id[2], id[1:0], none};
    end

endmodule

// File: rtl/rxq_irq_top.sv
`timescale 1ns/1ps
module rxq_irq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fifo_mode,
    input  logic [1:0]                  trig_sel,
    input  logic                        fifo_flush,
    input  logic [1:0]                  word_len,
    input  logic                        two_stop,
    input  logic                        baud_tick,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_byte,
    input  logic                        rx_pe,
    input  logic                        rx_fe,
    input  logic                        rx_bi,
    input  logic                        rd_pop,
    input  logic                        rd_lsr,
    input  logic                        ien_rx,
    input  logic                        ien_thre,
    input  logic                        ien_line,
    input  logic                        ien_modem,
    input  logic                        thr_empty,
    input  logic                        modem_event,
    output logic [7:0]                  head_byte,
    output logic                        head_pe,
    output logic                        head_fe,
    output logic                        head_bi,
    output logic [$clog2(DEPTH+1)-1:0]  fill_level,
    output logic [3:0]                  line_flags,
    output logic                        fifo_err,
    output logic [7:0]                  iir,
    output logic                        irq
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t        din, head;
    logic [CW-1:0]    cap, count;
    logic             mode_q, flush_all, accepted, ovf, to_flag, any_err;
    int               lvl;
    irq_src_t         src;

    assign flush_all = fifo_flush || (fifo_mode != mode_q);
    assign cap       = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign din       = '{data: rx_byte, pe: rx_pe, fe: rx_fe, bi: rx_bi};
    assign any_err   = rx_pe || rx_fe || rx_bi;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_mode;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_all),
        .push     (rx_valid),
        .pop      (rd_pop),
        .cap      (cap),
        .din      (din),
        .head     (head),
        .count    (count),
        .accepted (accepted),
        .ovf      (ovf)
    );

    rxq_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
        .clk       (clk),
        .rst       (rst),
        .enable    (fifo_mode),
        .has_data  (count != '0),
        .activity  (rx_valid || rd_pop || flush_all),
        .baud_tick (baud_tick),
        .word_len  (word_len),
        .two_stop  (two_stop),
        .timed_out (to_flag)
    );

    // sticky line flags {bi, fe, pe, oe}: new events win over a clearing read
    always_ff @(posedge clk) begin
        if (rst) line_flags <= '0;
        else     line_flags <= {accepted && rx_bi, accepted && rx_fe, accepted && rx_pe, ovf}
                             | (rd_lsr ? 4'b0000 : line_flags);
    end

    always_ff @(posedge clk) begin
        if (rst || flush_all)                   fifo_err <= 1'b0;
        else if (accepted && fifo_mode && any_err) fifo_err <= 1'b1;
        else if (rd_lsr)                        fifo_err <= 1'b0;
    end

    always_comb begin
        lvl       = fifo_mode ? trig_level(trig_sel) : 1;
        src.line  = ien_line  && (line_flags != '0);
        src.rda   = ien_rx    && (int'(count) >= lvl);
        src.cto   = ien_rx    && to_flag;
        src.thre  = ien_thre  && thr_empty;
        src.modem = ien_modem && modem_event;
    end

    rxq_prio u_prio (
        .fifo_mode (fifo_mode),
        .src       (src),
        .iir       (iir)
    );

    assign irq        = |src;
    assign head_byte  = head.data;
    assign head_pe    = head.pe;
    assign head_fe    = head.fe;
    assign head_bi    = head.bi;
    assign fill_level = count;

    assert_trigger_code_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_mode && ien_rx && !src.line && int'(count) >= trig_level(trig_sel)
        |-> iir[3:0] == 4'b0100);

    assert_line_first_R7: assert property (@(posedge clk) disable iff (rst)
        src.line |-> iir[3:0] == 4'b0110);

    assert_legacy_id_R8: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |-> (iir[7:6] == 2'b00) && !iir[3]);

    assert_ferr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        rd_lsr && !(rx_valid && any_err) |=> !fifo_err);

    assert_irq_match_R12: assert property (@(posedge clk) disable iff (rst)
        irq == !iir[0]);

endmodule

// File: tb/test_rxq_irq_top.sv
`timescale 1ns/1ps
module test_rxq_irq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_mode = 1'b1, fifo_flush = 1'b0, two_stop = 1'b0, baud_tick = 1'b0;
    logic [1:0] trig_sel = 2'b00, word_len = 2'b00;
    logic       rx_valid = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0, rx_bi = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_pop = 1'b0, rd_lsr = 1'b0;
    logic       ien_rx = 1'b0, ien_thre = 1'b0, ien_line = 1'b0, ien_modem = 1'b0;
    logic       thr_empty = 1'b0, modem_event = 1'b0;

    logic [7:0] head_byte, iir;
    logic       head_pe, head_fe, head_bi, fifo_err, irq;
    logic [4:0] fill_level;
    logic [3:0] line_flags;

    int  nchk = 0, nerr = 0;
    bit  run  = 1'b0;

    // reference model state
    int  mq[$];
    int  m_lf = 0, m_cnt = 0;
    bit  m_ferr = 1'b0, m_to = 1'b0, m_mode = 1'b0;

    always #10 clk = ~clk;

    rxq_irq_top i_rxq_irq_top (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
        .fifo_flush(fifo_flush), .word_len(word_len), .two_stop(two_stop),
        .baud_tick(baud_tick), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi), .rd_pop(rd_pop),
        .rd_lsr(rd_lsr), .ien_rx(ien_rx), .ien_thre(ien_thre),
        .ien_line(ien_line), .ien_modem(ien_modem), .thr_empty(thr_empty),
        .modem_event(modem_event), .head_byte(head_byte), .head_pe(head_pe),
        .head_fe(head_fe), .head_bi(head_bi), .fill_level(fill_level),
        .line_flags(line_flags), .fifo_err(fifo_err), .iir(iir), .irq(irq)
    );

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_iir();
        int lvl, code;
        lvl  = fifo_mode ? (trig_sel == 0 ? 1 : trig_sel == 1 ? 4 : trig_sel == 2 ? 8 : 14) : 1;
        if      (ien_line && m_lf != 0)          code = 6;
        else if (ien_rx && mq.size() >= lvl)     code = 4;
        else if (ien_rx && m_to)                 code = fifo_mode ? 12 : 4;
        else if (ien_thre && thr_empty)          code = 2;
        else if (ien_modem && modem_event)       code = 0;
        else                                     code = 1;
        return code + (fifo_mode ? 8'hC0 : 0);
    endfunction

    // behavioural model, advanced on each active edge
    always @(posedge clk) begin
        bit fl, full, dpop, dpush, ov;
        int cap, e;
        if (rst) begin
            mq.delete(); m_lf = 0; m_cnt = 0; m_to = 0; m_ferr = 0; m_mode = 0;
        end else begin
            fl  = fifo_flush || (fifo_mode != m_mode);
            cap = fifo_mode ? 16 : 1;
            if (!fifo_mode || rx_valid || rd_pop || fl || mq.size() == 0) begin
                m_cnt = 0; m_to = 0;
            end else if (baud_tick && !m_to) begin
                m_cnt++;
                if (m_cnt == 4 * (7 + word_len + two_stop)) m_to = 1;
            end
            full  = mq.size() >= cap;
            dpop  = !fl && rd_pop && mq.size() > 0;
            dpush = !fl && rx_valid && (!full || dpop);
            ov    = !fl && rx_valid && full && !dpop;
            e     = (rx_bi ? 8 : 0) + (rx_fe ? 4 : 0) + (rx_pe ? 2 : 0);
            m_lf  = (dpush ? e : 0) + (ov ? 1 : 0) + (rd_lsr ? 0 : m_lf);
            if (fl) m_ferr = 0;
            else if (dpush && fifo_mode && e != 0) m_ferr = 1;
            else if (rd_lsr) m_ferr = 0;
            if (fl) mq.delete();
            else begin
                if (dpop)  void'(mq.pop_front());
                if (dpush) mq.push_back(rx_byte + (rx_pe ? 256 : 0) + (rx_fe ? 512 : 0) + (rx_bi ? 1024 : 0));
            end
            m_mode = fifo_mode;
        end
    end

    always @(negedge clk) begin
        if (run && !rst) begin
            chk("R3 fill_level", fill_level, mq.size());
            if (mq.size() > 0)
                chk("R3 head", {head_bi, head_fe, head_pe, head_byte}, mq[0]);
            chk("R10 line_flags", line_flags, m_lf);
            chk("R9 fifo_err", fifo_err, m_ferr);
            chk("R7 iir", iir, exp_iir());
            chk("R12 irq", irq, (exp_iir() & 1) ? 0 : 1);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic push(input int d, input bit pe = 0, input bit fe = 0, input bit bi = 0);
        rx_valid = 1; rx_byte = d[7:0]; rx_pe = pe; rx_fe = fe; rx_bi = bi;
        cyc();
        rx_valid = 0; rx_pe = 0; rx_fe = 0; rx_bi = 0;
    endtask

    task automatic pop();
        rd_pop = 1; cyc(); rd_pop = 0;
    endtask

    task automatic read_lsr();
        rd_lsr = 1; cyc(); rd_lsr = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst = 0; run = 1;
        cyc();
        // reset state
        chk("R12 reset irq", irq, 0);
        chk("R8 reset iir", iir, 8'hC1);
        chk("R3 reset level", fill_level, 0);

        // R1 / R2: threshold of 4
        ien_rx = 1; trig_sel = 2'b01;
        push(8'h11); push(8'h22); push(8'h33);
        chk("R1 below threshold", iir, 8'hC1);
        push(8'h44);
        chk("R1 at threshold", iir, 8'hC4);
        chk("R12 irq raised", irq, 1);
        pop();
        chk("R2 self clear", iir, 8'hC1);
        chk("R3 order", head_byte, 8'h22);
        pop(); chk("R3 order", head_byte, 8'h33);
        pop(); chk("R3 order", head_byte, 8'h44);
        pop(); chk("R3 drained", fill_level, 0);

        // R4 / R7 / R10: threshold 14, fill and overrun
        trig_sel = 2'b11;
        for (int i = 0; i < 16; i++) begin
            push(8'h80 + i);
            if (i == 12) chk("R1 13 stored", iir, 8'hC1);
            if (i == 13) chk("R1 14 stored", iir, 8'hC4);
        end
        push(8'hEE);
        chk("R4 level held", fill_level, 16);
        chk("R4 overrun flag", line_flags, 4'b0001);
        chk("R10 line gated", iir, 8'hC4);
        ien_line = 1; #1;
        chk("R7 line wins", iir, 8'hC6);
        read_lsr();
        chk("R10 lsr clears", line_flags, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R4 contents kept", head_byte, 8'h80 + i);
            pop();
        end

        // R5: timeout, 8 data bits, 1 stop -> 40 ticks
        trig_sel = 2'b10; word_len = 2'd3; two_stop = 0;
        push(8'h5A);
        baud_tick = 1;
        repeat (39) cyc();
        chk("R5 before limit", iir, 8'hC1);
        cyc();
        chk("R5 timeout", iir, 8'hCC);
        baud_tick = 0;
        pop();
        chk("R5 cleared by read", iir, 8'hC1);
        // 5 data bits, 2 stop -> 32 ticks
        word_len = 2'd0; two_stop = 1;
        push(8'h5B);
        baud_tick = 1;
        repeat (31) cyc();
        chk("R5 short format before", iir, 8'hC1);
        cyc();
        chk("R5 short format", iir, 8'hCC);
        baud_tick = 0;
        fifo_flush = 1; cyc(); fifo_flush = 0;
        chk("R11 flush empties", fill_level, 0);
        chk("R11 flush clears timeout", iir, 8'hC1);

        // R9: error tracking
        ien_line = 0;
        push(8'h01, 1, 0, 0);
        chk("R9 set on parity", fifo_err, 1);
        chk("R10 parity flag", line_flags, 4'b0010);
        push(8'h02);
        read_lsr();
        chk("R9 lsr clears", fifo_err, 0);
        rd_lsr = 1; push(8'h03, 0, 0, 1); rd_lsr = 0;
        chk("R9 set wins", fifo_err, 1);
        push(8'h04, 0, 1, 0);
        fifo_flush = 1; cyc(); fifo_flush = 0;
        chk("R11 flush clears err", fifo_err, 0);
        read_lsr();

        // R6 / R8: single-character mode
        push(8'h09);
        fifo_mode = 0; cyc();
        chk("R11 mode change empties", fill_level, 0);
        chk("R8 legacy idle", iir, 8'h01);
        push(8'h61);
        chk("R8 legacy data", iir, 8'h04);
        push(8'h62);
        chk("R6 capacity one", fill_level, 1);
        chk("R6 overrun", line_flags, 4'b0001);
        chk("R6 head kept", head_byte, 8'h61);
        read_lsr();
        baud_tick = 1;
        repeat (100) cyc();
        baud_tick = 0;
        chk("R6 no timeout", iir, 8'h04);
        pop();
        chk("R8 legacy empty", iir, 8'h01);

        // R7 / R10 / R12: low-ranked sources
        ien_thre = 1; thr_empty = 1; cyc();
        chk("R7 thre", iir, 8'h02);
        modem_event = 1; cyc();
        chk("R7 thre over modem", iir, 8'h02);
        ien_thre = 0; cyc();
        chk("R10 modem gated", iir, 8'h01);
        ien_modem = 1; cyc();
        chk("R7 modem code", iir, 8'h00);
        chk("R12 modem irq", irq, 1);
        fifo_mode = 1; cyc();
        chk("R8 queue id", iir, 8'hC0);
        cyc(); cyc();
        run = 0;
        finish_run();
    end

endmodule